// File: doc/BRIEF.md
# AES Round Sequencing Controller

This controller paces an iterative AES encryption datapath that performs one cipher round per pass through shared hardware. While idle it watches three inputs: a block-valid flag, a mode flag that is low for encryption, and a ready flag from the round-key expansion logic. When all three allow it, the controller runs the rounds in order. First comes an initial round that only adds the key. Then comes a run of regular rounds. Last comes a final round that skips column mixing. Then the controller raises a finished flag.

For every round it drives two registered outputs. One is a round-key index that picks the expanded key applied in that round. The other is a two-bit round-type code that steers the multiplexer in front of the key-addition stage. The substitution stage is a clocked lookup table, so every round is held for one cycle beyond its lookup latency before the sequence advances. The round count follows from the key-length parameter. The lookup latency is a parameter as well.

Top module: `aes_round_sequencer`

## Requirements
- R1: The number of the final round is 10, 12 or 14 for a `KEY_BITS` of 128, 192 or 256.
- R2: A run starts only at a clock edge where `blk_valid` is 1, `dec_mode` is 0 and `rk_ready` is 1. Otherwise the idle outputs stay in place: code 0, index 0, finished 0.
- R3: In the initial round, `round_type` is 2'b00 (the raw block feeds key addition) and `rk_index` is 0.
- R4: In each regular round, `round_type` is 2'b01 (the column-mix output feeds key addition), and `rk_index` rises by exactly one from one round to the next.
- R5: In the final round, `round_type` is 2'b10 (the row-shift output feeds key addition with no column mixing) and `rk_index` equals the round count.
- R6: Each round holds its outputs for `SBOX_LAT`+1 cycles, which is 2 by default. With the start edge counted as edge 0, round r is shown after edges r·2 through r·2+1.
- R7: `finished` rises after edge (rounds+1)·2. It stays high with code 2'b10 and index equal to the round count for as long as `blk_valid` stays 1.
- R8: Once finished, the controller returns to idle only at the first edge where `blk_valid` is 0, so one valid assertion never starts a second run.
- R9: If `rk_ready` is 0 at an edge during a run, the next state is idle and `finished` stays 0. This also applies at the edge that would have completed the final round.
- R10: A synchronous active-high `rst` forces idle, code 2'b00, index 0 and `finished` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_valid | input | 1 | Input block is valid |
| dec_mode | input | 1 | 1 selects decryption, which this controller does not start |
| rk_ready | input | 1 | Round-key expansion complete |
| rk_index | output | 4 | Index of the round key for the current round |
| round_type | output | 2 | Key-addition input select: 00 initial, 01 regular, 10 final |
| finished | output | 1 | Run complete, result valid |

## Verification
The two functions that can fall in the same cycle are completion of the final round and the abort caused by the key-ready flag dropping. The bench runs the 128-bit instance until it is one edge from completion, then pulls `rk_ready` low exactly before that edge. It expects every instance to show idle outputs with `finished` still 0, so the abort must win. A second collision, reset arriving in the middle of a run, is checked the same way against the idle values.

// File: rtl/aes_seq_pkg.sv
package aes_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'b00,
    SEQ_RUN  = 2'b01,
    SEQ_DONE = 2'b10
  } seq_state_e;

  typedef enum logic [1:0] {
    RT_INIT    = 2'b00,
    RT_REGULAR = 2'b01,
    RT_FINAL   = 2'b10
  } round_type_e;

  function automatic int rounds_for(input int key_bits);
    if (key_bits <= 128)      return 10;
    else if (key_bits <= 192) return 12;
    else                      return 14;
  endfunction

endpackage

// File: rtl/aes_round_pacer.sv
module aes_round_pacer #(
  parameter int SBOX_LAT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic step
);
  localparam int HOLD  = SBOX_LAT + 1;
  localparam int CNT_W = $clog2(HOLD + 1);

  logic [CNT_W-1:0] cnt_q;

  assign step = en && (cnt_q == CNT_W'(HOLD - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) cnt_q <= '0;
    else if (step)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  // R6
  hold_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(HOLD - 1));

  // R6
  step_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && HOLD > 1) |=> !step);

endmodule

// File: rtl/aes_round_index.sv
module aes_round_index
  import aes_seq_pkg::*;
#(
  parameter int ROUNDS = 10,
  parameter int IDX_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  output logic [IDX_W-1:0] idx_q,
  output logic [1:0]       sel_q,
  output logic             at_last
);
  logic [IDX_W-1:0] idx_nxt;

  assign idx_nxt = idx_q + 1'b1;
  assign at_last = (idx_q == IDX_W'(ROUNDS));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx_q <= '0;
      sel_q <= RT_INIT;
    end else if (advance) begin
      idx_q <= idx_nxt;
      sel_q <= (idx_nxt == IDX_W'(ROUNDS)) ? RT_FINAL : RT_REGULAR;
    end
  end

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (advance && !clear) |=> (idx_q == $past(idx_q) + 1'b1));

  // R3
  init_code_chk: assert property (@(posedge clk) disable iff (rst)
    (idx_q == '0) |-> (sel_q == RT_INIT));

  // R5
  final_code_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == RT_FINAL) |-> (idx_q == IDX_W'(ROUNDS)));

endmodule

// File: rtl/aes_seq_fsm.sv
module aes_seq_fsm
  import aes_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_req,
  input  logic       key_ok,
  input  logic       data_valid,
  input  logic       last_step,
  output seq_state_e state_q,
  output seq_state_e state_nxt,
  output logic       done_q
);
  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      SEQ_IDLE: if (start_req) state_nxt = SEQ_RUN;
      SEQ_RUN: begin
        if (!key_ok)        state_nxt = SEQ_IDLE;
        else if (last_step) state_nxt = SEQ_DONE;
      end
      SEQ_DONE: if (!data_valid) state_nxt = SEQ_IDLE;
      default: state_nxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      done_q  <= (state_nxt == SEQ_DONE);
    end
  end

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_RUN && !key_ok) |=> (state_q == SEQ_IDLE && !done_q));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_DONE && data_valid) |=> (state_q == SEQ_DONE));

  // R2
  no_start_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEQ_IDLE && !start_req) |=> (state_q == SEQ_IDLE));

endmodule

// File: rtl/aes_round_sequencer.sv
module aes_round_sequencer
  import aes_seq_pkg::*;
#(
  parameter int KEY_BITS = 128,
  parameter int SBOX_LAT = 1,
  parameter int IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blk_valid,
  input  logic             dec_mode,
  input  logic             rk_ready,
  output logic [IDX_W-1:0] rk_index,
  output logic [1:0]       round_type,
  output logic             finished
);
  localparam int ROUNDS = rounds_for(KEY_BITS);

  seq_state_e state_q, state_nxt;
  logic       step, at_last, running, advance, last_step, start_req, clear;

  assign running   = (state_q == SEQ_RUN);
  assign start_req = blk_valid && !dec_mode && rk_ready;
  assign last_step = running && step && at_last;
  assign advance   = running && rk_ready && step && !at_last;
  assign clear     = (state_nxt == SEQ_IDLE);

  aes_seq_fsm i_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_req  (start_req),
    .key_ok     (rk_ready),
    .data_valid (blk_valid),
    .last_step  (last_step),
    .state_q    (state_q),
    .state_nxt  (state_nxt),
    .done_q     (finished)
  );

  aes_round_pacer #(.SBOX_LAT(SBOX_LAT)) i_pacer (
    .clk  (clk),
    .rst  (rst),
    .en   (running),
    .step (step)
  );

  aes_round_index #(.ROUNDS(ROUNDS), .IDX_W(IDX_W)) i_index (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear),
    .advance (advance),
    .idx_q   (rk_index),
    .sel_q   (round_type),
    .at_last (at_last)
  );

  // R7
  done_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    finished |-> (round_type == RT_FINAL && rk_index == IDX_W'(ROUNDS)));

  // R10
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!finished && rk_index == '0 && round_type == RT_INIT));

endmodule

// File: tb/test_aes_round_sequencer.sv
module test_aes_round_sequencer;
  localparam int HOLD = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic blk_valid = 1'b0, dec_mode = 1'b0, rk_ready = 1'b0;
  logic [3:0] idx_w [3];
  logic [1:0] sel_w [3];
  logic       fin_w [3];
  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  aes_round_sequencer #(.KEY_BITS(128)) i_aes_round_sequencer (
    .clk(clk), .rst(rst), .blk_valid(blk_valid), .dec_mode(dec_mode),
    .rk_ready(rk_ready), .rk_index(idx_w[0]), .round_type(sel_w[0]), .finished(fin_w[0]));
  aes_round_sequencer #(.KEY_BITS(192)) i_aes_round_sequencer_192 (
    .clk(clk), .rst(rst), .blk_valid(blk_valid), .dec_mode(dec_mode),
    .rk_ready(rk_ready), .rk_index(idx_w[1]), .round_type(sel_w[1]), .finished(fin_w[1]));
  aes_round_sequencer #(.KEY_BITS(256)) i_aes_round_sequencer_256 (
    .clk(clk), .rst(rst), .blk_valid(blk_valid), .dec_mode(dec_mode),
    .rk_ready(rk_ready), .rk_index(idx_w[2]), .round_type(sel_w[2]), .finished(fin_w[2]));

  function automatic int nrounds(input int k);
    return 10 + 2 * k;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmp(input int k, input string tag, input int e_idx, input int e_sel, input int e_fin);
    checks++;
    if (idx_w[k] != 4'(e_idx) || sel_w[k] != 2'(e_sel) || fin_w[k] != 1'(e_fin)) begin
      errors++;
      $display("FAIL %s inst%0d: idx=%0d sel=%0d fin=%0d expected idx=%0d sel=%0d fin=%0d",
               tag, k, idx_w[k], sel_w[k], fin_w[k], e_idx, e_sel, e_fin);
    end
  endtask

  task automatic check_idle(input string tag);
    for (int k = 0; k < 3; k++) cmp(k, tag, 0, 0, 0);
  endtask

  // j = edges after the start edge
  task automatic check_seq(input int j);
    for (int k = 0; k < 3; k++) begin
      int r, rnd;
      r = nrounds(k);
      rnd = j / HOLD;
      if (j >= (r + 1) * HOLD)  cmp(k, "R7,R8", r, 2, 1);
      else if (rnd == 0)        cmp(k, "R3,R6", 0, 0, 0);
      else if (rnd == r)        cmp(k, "R1,R5,R6", r, 2, 0);
      else                      cmp(k, "R4,R6", rnd, 1, 0);
    end
  endtask

  task automatic start_run();
    blk_valid = 1'b1; dec_mode = 1'b0; rk_ready = 1'b1;
    tick();
    check_seq(0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    check_idle("R10");
    rst = 1'b0;
    tick();
    check_idle("R10");

    // decrypt mode blocks start
    blk_valid = 1'b1; dec_mode = 1'b1; rk_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin tick(); check_idle("R2"); end
    // key not ready blocks start
    dec_mode = 1'b0; rk_ready = 1'b0;
    for (int i = 0; i < 5; i++) begin tick(); check_idle("R2"); end
    blk_valid = 1'b0; rk_ready = 1'b1;
    tick();

    // full run, valid held past completion
    start_run();
    for (int j = 1; j <= 38; j++) begin tick(); check_seq(j); end
    blk_valid = 1'b0;
    tick(); check_idle("R8");
    for (int i = 0; i < 3; i++) begin tick(); check_idle("R8"); end

    // abort in the middle of a run
    start_run();
    for (int j = 1; j <= 7; j++) begin tick(); check_seq(j); end
    rk_ready = 1'b0;
    tick(); check_idle("R9");
    blk_valid = 1'b0;
    tick(); check_idle("R9");
    rk_ready = 1'b1;
    tick();

    // abort on the edge that completes the 128-bit final round
    start_run();
    for (int j = 1; j <= 21; j++) begin tick(); check_seq(j); end
    rk_ready = 1'b0;
    tick(); check_idle("R9");
    tick(); check_idle("R9");
    blk_valid = 1'b0; rk_ready = 1'b1;
    tick();

    // reset in the middle of a run
    start_run();
    for (int j = 1; j <= 5; j++) begin tick(); check_seq(j); end
    rst = 1'b1; blk_valid = 1'b0;
    tick(); check_idle("R10");
    rst = 1'b0;
    tick(); check_idle("R10");

    // second complete run after recovery
    start_run();
    for (int j = 1; j <= 31; j++) begin tick(); check_seq(j); end
    blk_valid = 1'b0;
    tick(); check_idle("R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule